// File: doc/BRIEF.md
# Inter-Processor Command Mailbox

This block joins a main processor and a sound coprocessor through a pair of byte registers. There is no memory window that both processors can reach. The main processor sends a command byte by writing to its single mailbox location. The block latches that byte and raises a non-maskable interrupt request toward the sound processor. The sound processor fetches the command from its I/O port 0x00 and answers by writing a reply byte to its I/O port 0x0C. That reply goes into a separate latch. The main processor reads the reply back at the same location it writes commands to. Writing a reply raises no interrupt toward the main processor.

Both bus sides use plain synchronous strobes that are one clock cycle wide. Two flags give each side a view of the traffic. The command-pending flag shows that a command has not been fetched yet. The reply-valid flag shows that a reply has not been read yet. A build parameter selects how the interrupt request behaves:
- Pulse mode gives a one-cycle pulse for each command write.
- Level mode holds the request high until the sound processor fetches the command.

Top module: `cmd_mailbox`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: both latches, both flags, and the interrupt request.
- R2: A main-side write (`host_wr`) latches `host_wdata` as the command and sets `cmd_pending` on the next clock edge. While `snd_addr` is 0x00, `snd_rdata` shows the command latch; at any other address it reads 0x00.
- R3: In pulse mode (`NMI_MODE` = `NMI_PULSE`), `snd_nmi` is high for exactly the one cycle that follows each command write.
- R4: In level mode (`NMI_MODE` = `NMI_LEVEL`), `snd_nmi` rises on the edge that latches a command. It stays high until the edge on which the sound side reads port 0x00.
- R5: A sound-side write (`snd_wr`) with `snd_addr` = 0x0C latches `snd_wdata` as the reply and sets `reply_valid`. It never raises `snd_nmi`.
- R6: `host_rdata` always shows the reply latch. A command write leaves it unchanged.
- R7: A sound-side read of port 0x00 clears `cmd_pending`. A read of any other port leaves `cmd_pending` and the interrupt request unchanged.
- R8: A main-side read (`host_rd`) clears `reply_valid` and leaves the reply byte unchanged.
- R9: A new command write replaces an unread command: the last byte written wins.
- R10: When a flag is set and cleared in the same cycle, setting takes priority and the flag ends up 1.
- R11: A sound-side write to any port other than 0x0C leaves the reply latch and `reply_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both bus sides |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Main-side write strobe that sends a command |
| host_rd | input | 1 | Main-side read strobe that consumes the reply |
| host_wdata | input | 8 | Command byte |
| host_rdata | output | 8 | Reply latch contents |
| cmd_pending | output | 1 | A command is waiting to be fetched |
| reply_valid | output | 1 | A reply is waiting to be read |
| snd_rd | input | 1 | Sound-side I/O read strobe |
| snd_wr | input | 1 | Sound-side I/O write strobe |
| snd_addr | input | 8 | Sound-side I/O port number |
| snd_wdata | input | 8 | Sound-side I/O write data |
| snd_rdata | output | 8 | Sound-side I/O read data |
| snd_nmi | output | 1 | Interrupt request to the sound processor |

## Verification
The bench builds two copies of the block with the default 8-bit data and I/O address widths and the default port numbers 0x00 and 0x0C. The copy named `uut` uses pulse mode and the copy named `uut_lvl` uses level mode. Both copies receive the same stimulus, so one command sequence checks the single-cycle pulse and the held level side by side. With both copies in place, the bench can also show that reads of other ports or writes to other ports touch neither copy. Back-to-back writes and same-cycle set/clear strobes reach the overwrite and set-priority cases.

// File: rtl/mbx_pkg.sv
// Package: shared types for the command mailbox.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package mbx_pkg;
    // Interrupt request behaviour toward the sound processor.
    typedef enum logic {
        NMI_PULSE = 1'b0,   // one-cycle pulse for each command write
        NMI_LEVEL = 1'b1    // held until the command is fetched
    } nmi_mode_e;
endpackage

// File: rtl/mbx_byte_latch.sv
// Module: mbx_byte_latch
// Holds one data byte and a "full" flag. A load captures the data and sets
// the flag. A consume clears the flag. If load and consume arrive in the
// same cycle, the load wins.
// Assumes: load and consume are single-cycle strobes synchronous to clk.
module mbx_byte_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              consume,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_q,
    output logic              full
);
    // Data register: capture on load; the last load wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (load)
            data_q <= data_in;
    end

    // Flag register: set on load, clear on consume, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (load)
            full <= 1'b1;
        else if (consume)
            full <= 1'b0;
    end

    // R9: every load captures the newest byte and marks the latch full
    assert_load_captures_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (data_q == $past(data_in)) && full);

    // R10: when load and consume coincide, the flag stays set
    assert_set_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && consume) |=> full);

    // R7/R8: a lone consume clears the flag
    assert_consume_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !load) |=> !full);

    // R11: with no load, the data byte holds its value
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(data_q));
endmodule

// File: rtl/mbx_nmi_gen.sv
// Module: mbx_nmi_gen
// Produces the interrupt request toward the sound processor, in one of two
// variants chosen at build time:
//   - pulse: high for one cycle after each trigger;
//   - level: high from a trigger until an acknowledge.
// Assumes: trigger and ack are single-cycle strobes; in level mode a
// trigger overrides an ack that arrives in the same cycle.
module mbx_nmi_gen
    import mbx_pkg::*;
#(
    parameter nmi_mode_e MODE = NMI_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic ack,
    output logic nmi
);
    logic nmi_q;

    generate
        if (MODE == NMI_PULSE) begin : g_pulse
            // Pulse register: echoes the trigger strobe one cycle later.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    nmi_q <= 1'b0;
                else
                    nmi_q <= trigger;
            end

            // R3: a trigger gives a request on the next cycle
            assert_pulse_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
                trigger |=> nmi);
            // R3: with no trigger, the request is low on the next cycle
            assert_pulse_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
                !trigger |=> !nmi);
        end else begin : g_level
            // Level register: set by trigger, cleared by acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    nmi_q <= 1'b0;
                else if (trigger)
                    nmi_q <= 1'b1;
                else if (ack)
                    nmi_q <= 1'b0;
            end

            // R4: a trigger raises the level
            assert_level_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
                trigger |=> nmi);
            // R4: a lone acknowledge drops the level
            assert_level_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (ack && !trigger) |=> !nmi);
            // R7: with neither strobe, the level holds
            assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!ack && !trigger) |=> $stable(nmi));
        end
    endgenerate

    assign nmi = nmi_q;
endmodule

// File: rtl/mbx_snd_decode.sv
// Module: mbx_snd_decode
// Decodes the sound processor's I/O strobes into two events: a command
// fetch and a reply store. It also selects the sound-side read data.
// Assumes: the port numbers are distinct, and an unmapped port reads zero.
module mbx_snd_decode #(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CMD_PORT   = 'h00,
    parameter logic [ADDR_W-1:0] REPLY_PORT = 'h0C
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] cmd_byte,
    output logic              cmd_fetch,
    output logic              reply_store,
    output logic [DATA_W-1:0] io_rdata
);
    logic hit_cmd;
    logic hit_reply;

    // Port match: compare the address against both mailbox ports.
    always_comb begin
        hit_cmd   = (io_addr == CMD_PORT);
        hit_reply = (io_addr == REPLY_PORT);
    end

    // Event decode: qualify the port matches with the strobes.
    always_comb begin
        cmd_fetch   = io_rd && hit_cmd;
        reply_store = io_wr && hit_reply;
    end

    // Read mux: the command byte appears only at the command port.
    always_comb begin
        io_rdata = hit_cmd ? cmd_byte : '0;
    end

    // Configuration check: both ports must differ.
    initial begin
        assert_ports_distinct_R2: assert (CMD_PORT != REPLY_PORT);
    end
endmodule

// File: rtl/cmd_mailbox.sv
// Module: cmd_mailbox
// Byte-wide mailbox between a main processor and a sound processor.
// Command path: a main-side write stores a command byte and triggers the
// interrupt request. Reply path: a sound-side write to the reply port stores
// a byte that the main side reads at its single location.
// Assumes: both sides run on clk with single-cycle strobes.
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CMD_PORT   = 'h00,
    parameter logic [ADDR_W-1:0] REPLY_PORT = 'h0C,
    parameter nmi_mode_e         NMI_MODE   = NMI_PULSE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              cmd_pending,
    output logic              reply_valid,
    input  logic              snd_rd,
    input  logic              snd_wr,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic [DATA_W-1:0] snd_wdata,
    output logic [DATA_W-1:0] snd_rdata,
    output logic              snd_nmi
);
    logic              cmd_fetch;
    logic              reply_store;
    logic [DATA_W-1:0] cmd_byte;

    // Sound-side decode of the port strobes and read data.
    mbx_snd_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CMD_PORT   (CMD_PORT),
        .REPLY_PORT (REPLY_PORT)
    ) u_decode (
        .io_addr     (snd_addr),
        .io_rd       (snd_rd),
        .io_wr       (snd_wr),
        .cmd_byte    (cmd_byte),
        .cmd_fetch   (cmd_fetch),
        .reply_store (reply_store),
        .io_rdata    (snd_rdata)
    );

    // Command latch: loaded by the main side, consumed by the sound side.
    mbx_byte_latch #(.DATA_W(DATA_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (host_wr),
        .consume (cmd_fetch),
        .data_in (host_wdata),
        .data_q  (cmd_byte),
        .full    (cmd_pending)
    );

    // Reply latch: loaded by the sound side, consumed by the main side.
    mbx_byte_latch #(.DATA_W(DATA_W)) u_reply (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reply_store),
        .consume (host_rd),
        .data_in (snd_wdata),
        .data_q  (host_rdata),
        .full    (reply_valid)
    );

    // Interrupt request: triggered only by command writes.
    mbx_nmi_gen #(.MODE(NMI_MODE)) u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (host_wr),
        .ack     (cmd_fetch),
        .nmi     (snd_nmi)
    );

    // R5: every rising edge of the request follows a command write
    assert_nmi_from_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snd_nmi) |-> $past(host_wr));

    // R6: the main-side read data changes only through a reply store
    assert_reply_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reply_store |=> $stable(host_rdata));

    // R2: a command write is visible as pending on the next cycle
    assert_cmd_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> cmd_pending);
endmodule

// File: tb/cmd_mailbox_test.sv
// Directed bench: two copies of the mailbox, one in pulse mode and one in
// level mode, driven with the same stimulus.
module cmd_mailbox_test;
    import mbx_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       snd_rd = 1'b0, snd_wr = 1'b0;
    logic [7:0] snd_addr = 8'h00, snd_wdata = 8'h00;

    logic [7:0] host_rdata, snd_rdata, host_rdata_l, snd_rdata_l;
    logic       cmd_pending, reply_valid, snd_nmi;
    logic       cmd_pending_l, reply_valid_l, nmi_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmd_mailbox #(.NMI_MODE(NMI_PULSE)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_pending(cmd_pending), .reply_valid(reply_valid),
        .snd_rd(snd_rd), .snd_wr(snd_wr), .snd_addr(snd_addr),
        .snd_wdata(snd_wdata), .snd_rdata(snd_rdata), .snd_nmi(snd_nmi)
    );

    cmd_mailbox #(.NMI_MODE(NMI_LEVEL)) uut_lvl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata_l),
        .cmd_pending(cmd_pending_l), .reply_valid(reply_valid_l),
        .snd_rd(snd_rd), .snd_wr(snd_wr), .snd_addr(snd_addr),
        .snd_wdata(snd_wdata), .snd_rdata(snd_rdata_l), .snd_nmi(nmi_lvl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle strobe helpers: drive at negedge, release at next negedge.
    task automatic host_write(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic host_read();
        host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic snd_read(input logic [7:0] a);
        snd_addr = a; snd_rd = 1'b1;
        @(negedge clk); snd_rd = 1'b0;
    endtask

    task automatic snd_write(input logic [7:0] a, input logic [7:0] d);
        snd_addr = a; snd_wdata = d; snd_wr = 1'b1;
        @(negedge clk); snd_wr = 1'b0;
    endtask

    task automatic t_reset();
        snd_addr = 8'h00;
        chk("R1 cmd_pending", cmd_pending, 0);
        chk("R1 reply_valid", reply_valid, 0);
        chk("R1 host_rdata", host_rdata, 0);
        chk("R1 snd_rdata", snd_rdata, 0);
        chk("R1 nmi pulse", snd_nmi, 0);
        chk("R1 nmi level", nmi_lvl, 0);
    endtask

    task automatic t_command();
        snd_addr = 8'h00;
        host_write(8'h5A);
        chk("R2 pending set", cmd_pending, 1);
        chk("R2 snd_rdata", snd_rdata, 8'h5A);
        chk("R3 pulse high", snd_nmi, 1);
        chk("R4 level high", nmi_lvl, 1);
        chk("R6 host_rdata unchanged", host_rdata, 0);
        snd_addr = 8'h07;
        #1 chk("R2 other port reads zero", snd_rdata, 0);
        @(negedge clk);
        chk("R3 pulse one cycle", snd_nmi, 0);
        chk("R4 level held", nmi_lvl, 1);
    endtask

    task automatic t_fetch();
        snd_read(8'h05);
        chk("R7 other port keeps pending", cmd_pending, 1);
        chk("R7 other port keeps level", nmi_lvl, 1);
        snd_read(8'h00);
        chk("R7 fetch clears pending", cmd_pending, 0);
        chk("R4 fetch clears level", nmi_lvl, 0);
        chk("R4 level mode pending", cmd_pending_l, 0);
    endtask

    task automatic t_reply();
        snd_write(8'h0C, 8'h81);
        chk("R5 reply_valid", reply_valid, 1);
        chk("R6 host_rdata reply", host_rdata, 8'h81);
        chk("R5 no pulse", snd_nmi, 0);
        chk("R5 no level", nmi_lvl, 0);
        snd_write(8'h0D, 8'h33);
        chk("R11 other port ignored", host_rdata, 8'h81);
        chk("R11 level copy ignored", host_rdata_l, 8'h81);
        chk("R11 no nmi", snd_nmi, 0);
        host_read();
        chk("R8 reply_valid cleared", reply_valid, 0);
        chk("R8 reply byte kept", host_rdata, 8'h81);
        snd_write(8'h01, 8'h44);
        chk("R11 valid stays clear", reply_valid, 0);
    endtask

    task automatic t_overwrite();
        snd_addr = 8'h00;
        host_write(8'h11);
        host_write(8'h22);
        chk("R9 last write wins", snd_rdata, 8'h22);
        chk("R9 pending", cmd_pending, 1);
        chk("R3 back-to-back pulse", snd_nmi, 1);
        snd_read(8'h00);
        chk("R9 fetch clears", cmd_pending, 0);
    endtask

    task automatic t_collide();
        // A command write and a command fetch in the same cycle.
        snd_addr = 8'h00; snd_rd = 1'b1; host_wr = 1'b1; host_wdata = 8'h44;
        @(negedge clk); snd_rd = 1'b0; host_wr = 1'b0;
        chk("R10 pending set wins", cmd_pending, 1);
        chk("R10 new byte", snd_rdata, 8'h44);
        chk("R10 level set wins", nmi_lvl, 1);
        // A reply store and a reply read in the same cycle.
        snd_addr = 8'h0C; snd_wdata = 8'h9C; snd_wr = 1'b1; host_rd = 1'b1;
        @(negedge clk); snd_wr = 1'b0; host_rd = 1'b0;
        chk("R10 reply set wins", reply_valid, 1);
        chk("R10 reply byte", host_rdata, 8'h9C);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_command();
        t_fetch();
        t_reply();
        t_overwrite();
        t_collide();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule